// File: doc/BRIEF.md
# UART Receive Front End with Start-Bit Validation

This block is the receive side of an asynchronous serial port. It watches a serial line, paced by a sampling enable that pulses sixteen times per bit period, and turns each incoming frame into a character. A falling edge on the idle line is only a candidate start bit. The line is looked at again at the middle of that bit, and a short low pulse sends the receiver back to idle without producing anything. Once a start bit is accepted, the data bits, the optional parity bit and the stop bit are each sampled at their bit centres.

Every completed character is announced with a one-cycle push strobe and is written into an internal receive queue. Each entry carries its own parity, framing and break flags. The reader drains the queue with a pop input. The oldest entry and its flags are always visible at the outputs. The data-ready flag follows the queue occupancy. Overrun is reported when a character arrives at a full queue. A summary flag stays up while any queued entry carries an error.

The sampling enable, the serial input and the frame configuration come from the surrounding port logic. The serial input is assumed to be already synchronised to the clock. The frame configuration must stay stable while a frame is being received.

Top module: `uart_rx_front`

## Requirements
- R1: A low line, sampled on a sampling tick right after a tick that sampled it high while the receiver is idle, starts a candidate start bit. On the 8th following tick the line is sampled again. If it is high, the candidate is dropped, the receiver returns to idle and no character is produced. If it is low, reception of the frame begins.
- R2: After an accepted start bit, one bit is sampled every 16 ticks. The data bits come first, least significant bit first. `word_len_i` selects how many: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. The data bits are followed by the parity bit (only when enabled) and then one stop bit. Unused upper data bits read as zero.
- R3: `push_o` is high for exactly one clock cycle: the cycle after the tick on which the stop bit was sampled. `push_data_o` carries the character during that cycle.
- R4: When `parity_en_i` is 1, the parity bit is checked. With `parity_even_i` = 1, the data bits plus the parity bit must hold an even number of ones. With `parity_even_i` = 0, they must hold an odd number. A mismatch sets that character's parity flag.
- R5: A stop bit sampled low sets that character's framing flag.
- R6: When every data bit, the parity bit (if present) and the stop bit are all low, the character's break flag is set. Its framing flag is set as well.
- R7: A character is accepted into the queue when fewer than FIFO_DEPTH entries are held. `data_ready_o` is high whenever at least one entry is held. It rises in the cycle after the push strobe and falls once the queue is empty. `rd_data_o` shows the oldest entry. `pop_i` removes the oldest entry and has no effect when the queue is empty.
- R8: A character that completes while FIFO_DEPTH entries are held is discarded. It raises `err_overrun_o` from the cycle after its push strobe. The flag stays up until a pop removes an entry.
- R9: `err_parity_o`, `err_frame_o` and `err_break_o` show the flags of the oldest entry. These flags and `rd_data_o` are zero while the queue is empty.
- R10: `fifo_err_o` is high exactly while at least one held entry has its parity, framing or break flag set.
- R11: After reset the receiver is idle and the queue is empty. Every output is low, and the line is treated as previously high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick16_i | input | 1 | Sampling enable, 16 pulses per bit period |
| rxd_i | input | 1 | Synchronised serial input, idle high |
| word_len_i | input | 2 | Data bits: 0=5, 1=6, 2=7, 3=8 |
| parity_en_i | input | 1 | A parity bit follows the data bits |
| parity_even_i | input | 1 | 1 selects even parity, 0 odd |
| pop_i | input | 1 | Remove the oldest queue entry |
| push_o | output | 1 | One-cycle strobe for a completed character |
| push_data_o | output | 8 | Character during the strobe |
| data_ready_o | output | 1 | Queue holds at least one entry |
| rd_data_o | output | 8 | Oldest queued character |
| err_parity_o | output | 1 | Parity flag of the oldest entry |
| err_frame_o | output | 1 | Framing flag of the oldest entry |
| err_break_o | output | 1 | Break flag of the oldest entry |
| err_overrun_o | output | 1 | A character was lost to a full queue |
| fifo_err_o | output | 1 | Some queued entry carries an error |

## Verification
The push strobe and its character appear one cycle after the clock edge at which the tick sampling the stop bit is taken. The queue view (`data_ready_o`, `rd_data_o`, the head flags, `fifo_err_o`) and `err_overrun_o` change one edge after that strobe, or one edge after a pop. The bench keeps a behavioural model that steps on each rising edge in this same order: first the queue acts on the strobe the model produced in the previous cycle, then the framer acts on the current tick. Every output is compared with the model at the following falling edge. Directed checks are made only after a 16-tick idle gap has followed the stop bit, well past both latencies.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2
    } rx_state_e;

    // One received character with its per-character error flags
    typedef struct packed {
        logic [7:0] data;
        logic       perr;
        logic       ferr;
        logic       brk;
    } rx_char_t;

endpackage

// File: rtl/rx_framer.sv
module rx_framer
    import uart_rx_pkg::*;
#(
    parameter int OVERSAMPLE = 16
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       tick_i,
    input  logic       rxd_i,
    input  logic [1:0] word_len_i,
    input  logic       parity_en_i,
    input  logic       parity_even_i,
    output logic       push_o,
    output rx_char_t   char_o
);
    localparam int CNT_W = $clog2(OVERSAMPLE);
    localparam int MID   = OVERSAMPLE / 2;

    typedef struct packed {
        rx_state_e      state;
        logic [CNT_W-1:0] cnt;
        logic [3:0]     idx;
        logic           prev;
        logic [7:0]     data;
        logic           par_acc;
        logic           seen_one;
        logic           push;
        rx_char_t       chr;
    } fr_regs_t;

    fr_regs_t q, d;

    logic [3:0] n_data;
    logic [3:0] last_idx;

    assign n_data   = {2'b00, word_len_i} + 4'd5;
    assign last_idx = n_data + {3'b000, parity_en_i};

    always_comb begin
        d      = q;
        d.push = 1'b0;
        if (tick_i) begin
            d.prev = rxd_i;
            unique case (q.state)
                RX_IDLE: begin
                    if (q.prev && !rxd_i) begin
                        d.state = RX_START;
                        d.cnt   = '0;
                    end
                end
                RX_START: begin
                    if (q.cnt == CNT_W'(MID - 1)) begin
                        if (!rxd_i) begin
                            d.state    = RX_DATA;
                            d.cnt      = '0;
                            d.idx      = '0;
                            d.data     = '0;
                            d.par_acc  = 1'b0;
                            d.seen_one = 1'b0;
                        end else begin
                            d.state = RX_IDLE;
                        end
                    end else begin
                        d.cnt = q.cnt + CNT_W'(1);
                    end
                end
                RX_DATA: begin
                    if (q.cnt == CNT_W'(OVERSAMPLE - 1)) begin
                        d.cnt      = '0;
                        d.idx      = q.idx + 4'd1;
                        d.seen_one = q.seen_one | rxd_i;
                        if (q.idx < n_data) begin
                            d.data[q.idx[2:0]] = rxd_i;
                        end
                        if (q.idx < last_idx) begin
                            d.par_acc = q.par_acc ^ rxd_i;
                        end
                        if (q.idx == last_idx) begin
                            d.state    = RX_IDLE;
                            d.push     = 1'b1;
                            d.chr.data = q.data;
                            d.chr.perr = parity_en_i & (q.par_acc ^ ~parity_even_i);
                            d.chr.ferr = ~rxd_i;
                            d.chr.brk  = ~q.seen_one & ~rxd_i;
                        end
                    end else begin
                        d.cnt = q.cnt + CNT_W'(1);
                    end
                end
                default: d.state = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q       <= '0;
            q.state <= RX_IDLE;
            q.prev  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign push_o = q.push;
    assign char_o = q.chr;

    // R1: an idle receiver can only move to start validation, never straight to data
    assert_idle_to_start_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.state == RX_IDLE) |=> (q.state != RX_DATA));

    // R3: a strobe follows a sampling tick and lasts one cycle
    assert_push_after_tick_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q.push |-> $past(tick_i));
    assert_push_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q.push |=> !q.push);

    // R6: a break is always also a framing error
    assert_break_frames_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.push && q.chr.brk) |-> q.chr.ferr);

endmodule

// File: rtl/rx_fifo.sv
module rx_fifo
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic     clk_i,
    input  logic     rst_ni,
    input  logic     push_i,
    input  rx_char_t char_i,
    input  logic     pop_i,
    output rx_char_t head_o,
    output logic     ready_o,
    output logic     overrun_o,
    output logic     any_err_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        rx_char_t [DEPTH-1:0] mem;
        logic [PTR_W-1:0]     wr_ptr;
        logic [PTR_W-1:0]     rd_ptr;
        logic [CNT_W-1:0]     count;
        logic [CNT_W-1:0]     err_cnt;
        logic                 ovr;
    } fifo_regs_t;

    fifo_regs_t q, d;

    logic     pop_eff;
    logic     accept;
    logic     in_err;
    logic     head_err;
    rx_char_t head_raw;

    assign head_raw = q.mem[q.rd_ptr];
    assign pop_eff  = pop_i && (q.count != '0);
    assign accept   = push_i && (q.count < CNT_W'(DEPTH));
    assign in_err   = char_i.perr | char_i.ferr | char_i.brk;
    assign head_err = head_raw.perr | head_raw.ferr | head_raw.brk;

    always_comb begin
        d = q;
        if (accept) begin
            d.mem[q.wr_ptr] = char_i;
            d.wr_ptr = (q.wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : q.wr_ptr + PTR_W'(1);
        end
        if (pop_eff) begin
            d.rd_ptr = (q.rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : q.rd_ptr + PTR_W'(1);
        end
        d.count   = q.count + CNT_W'(accept) - CNT_W'(pop_eff);
        d.err_cnt = q.err_cnt + CNT_W'(accept && in_err) - CNT_W'(pop_eff && head_err);
        if (push_i && !accept) begin
            d.ovr = 1'b1;
        end else if (pop_eff) begin
            d.ovr = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign ready_o   = (q.count != '0);
    assign head_o    = ready_o ? head_raw : '0;
    assign overrun_o = q.ovr;
    assign any_err_o = (q.err_cnt != '0);

    // R7: occupancy never passes the depth
    assert_no_overflow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q.count <= CNT_W'(DEPTH));

    // R8: a strobe arriving at a full queue raises overrun
    assert_overrun_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (push_i && q.count == CNT_W'(DEPTH)) |=> overrun_o);

    // R9: nothing is shown while empty
    assert_empty_head_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ready_o |-> (head_o == '0));

    // R10: errored entries are a subset of held entries
    assert_errcnt_bound_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q.err_cnt <= q.count);

endmodule

// File: rtl/uart_rx_front.sv
module uart_rx_front
    import uart_rx_pkg::*;
#(
    parameter int OVERSAMPLE = 16,
    parameter int FIFO_DEPTH = 8
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       tick16_i,
    input  logic       rxd_i,
    input  logic [1:0] word_len_i,
    input  logic       parity_en_i,
    input  logic       parity_even_i,
    input  logic       pop_i,
    output logic       push_o,
    output logic [7:0] push_data_o,
    output logic       data_ready_o,
    output logic [7:0] rd_data_o,
    output logic       err_parity_o,
    output logic       err_frame_o,
    output logic       err_break_o,
    output logic       err_overrun_o,
    output logic       fifo_err_o
);
    logic     push;
    rx_char_t chr;
    rx_char_t head;

    rx_framer #(.OVERSAMPLE(OVERSAMPLE)) i_framer (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .tick_i        (tick16_i),
        .rxd_i         (rxd_i),
        .word_len_i    (word_len_i),
        .parity_en_i   (parity_en_i),
        .parity_even_i (parity_even_i),
        .push_o        (push),
        .char_o        (chr)
    );

    rx_fifo #(.DEPTH(FIFO_DEPTH)) i_fifo (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .push_i    (push),
        .char_i    (chr),
        .pop_i     (pop_i),
        .head_o    (head),
        .ready_o   (data_ready_o),
        .overrun_o (err_overrun_o),
        .any_err_o (fifo_err_o)
    );

    assign push_o       = push;
    assign push_data_o  = chr.data;
    assign rd_data_o    = head.data;
    assign err_parity_o = head.perr;
    assign err_frame_o  = head.ferr;
    assign err_break_o  = head.brk;

    // R7: data ready rises only after a strobe
    assert_ready_after_push_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(data_ready_o) |-> $past(push));

endmodule

// File: tb/test_uart_rx_front.sv
module test_uart_rx_front;
    localparam int DEPTH = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       rxd = 1'b1;
    logic [1:0] word_len = 2'd3;
    logic       par_en = 1'b0;
    logic       par_even = 1'b0;
    logic       pop = 1'b0;
    logic       push_o, data_ready_o, err_parity_o, err_frame_o, err_break_o;
    logic       err_overrun_o, fifo_err_o;
    logic [7:0] push_data_o, rd_data_o;

    int checks = 0;
    int fails = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    uart_rx_front #(.OVERSAMPLE(16), .FIFO_DEPTH(DEPTH)) i_uart_rx_front (
        .clk_i(clk), .rst_ni(rst_n), .tick16_i(tick), .rxd_i(rxd),
        .word_len_i(word_len), .parity_en_i(par_en), .parity_even_i(par_even),
        .pop_i(pop), .push_o(push_o), .push_data_o(push_data_o),
        .data_ready_o(data_ready_o), .rd_data_o(rd_data_o),
        .err_parity_o(err_parity_o), .err_frame_o(err_frame_o),
        .err_break_o(err_break_o), .err_overrun_o(err_overrun_o),
        .fifo_err_o(fifo_err_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    typedef struct {
        int data;
        bit p;
        bit f;
        bit b;
    } ent_t;

    ent_t mq[$];
    ent_t m_chr;
    bit   m_push = 0;
    bit   m_ovr = 0;
    bit   m_prev = 1;
    int   m_phase = 0;
    int   m_ticks = 0;
    int   m_nrx = 0;
    bit   m_bits[16];

    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete();
            m_push = 0; m_ovr = 0; m_prev = 1; m_phase = 0; m_ticks = 0; m_nrx = 0;
        end else begin
            bit pe, acc;
            int nb, np;
            pe  = pop && (mq.size() > 0);
            acc = m_push && (mq.size() < DEPTH);
            if (pe) void'(mq.pop_front());
            if (acc) mq.push_back(m_chr);
            if (m_push && !acc) m_ovr = 1;
            else if (pe) m_ovr = 0;
            m_push = 0;
            nb = 5 + int'(word_len);
            np = par_en ? 1 : 0;
            if (tick) begin
                if (m_phase == 0) begin
                    if (m_prev && !rxd) begin m_phase = 1; m_ticks = 0; end
                end else if (m_phase == 1) begin
                    m_ticks++;
                    if (m_ticks == 8) begin
                        if (!rxd) begin m_phase = 2; m_ticks = 0; m_nrx = 0; end
                        else m_phase = 0;
                    end
                end else begin
                    m_ticks++;
                    if (m_ticks == 16) begin
                        m_ticks = 0;
                        m_bits[m_nrx] = rxd;
                        m_nrx++;
                        if (m_nrx == nb + np + 1) begin
                            int ones, allz;
                            m_chr.data = 0; ones = 0; allz = 1;
                            for (int i = 0; i < nb; i++) m_chr.data += int'(m_bits[i]) << i;
                            for (int i = 0; i < nb + np; i++) ones += int'(m_bits[i]);
                            for (int i = 0; i < m_nrx; i++) if (m_bits[i]) allz = 0;
                            m_chr.p = (np == 1) && (par_even ? (ones % 2 == 1) : (ones % 2 == 0));
                            m_chr.f = !m_bits[m_nrx-1];
                            m_chr.b = (allz == 1);
                            m_push = 1;
                            m_phase = 0;
                        end
                    end
                end
                m_prev = rxd;
            end
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            int anyerr;
            chk("R3 push strobe", int'(push_o), int'(m_push));
            if (m_push) chk("R2 push data", int'(push_data_o), m_chr.data);
            chk("R7 data ready", int'(data_ready_o), int'(mq.size() > 0));
            chk("R7 head data", int'(rd_data_o), mq.size() > 0 ? mq[0].data : 0);
            chk("R4 head parity flag", int'(err_parity_o), mq.size() > 0 ? int'(mq[0].p) : 0);
            chk("R5 head framing flag", int'(err_frame_o), mq.size() > 0 ? int'(mq[0].f) : 0);
            chk("R6 head break flag", int'(err_break_o), mq.size() > 0 ? int'(mq[0].b) : 0);
            chk("R8 overrun", int'(err_overrun_o), int'(m_ovr));
            anyerr = 0;
            foreach (mq[i]) if (mq[i].p || mq[i].f || mq[i].b) anyerr = 1;
            chk("R10 fifo error", int'(fifo_err_o), anyerr);
        end
    end

    // ---------------- stimulus ----------------
    task automatic line(input int n, input logic v);
        rxd = v;
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
            repeat (3) @(negedge clk);
        end
    endtask

    task automatic send_frame(input logic [7:0] d, input int nb, input bit pen,
                              input bit peven, input bit pflip, input bit stopv);
        int   ones;
        logic pb;
        word_len = 2'(nb - 5);
        par_en   = pen;
        par_even = peven;
        ones = 0;
        for (int i = 0; i < nb; i++) ones += int'(d[i]);
        pb = peven ? ones[0] : ~ones[0];
        if (pflip) pb = ~pb;
        line(16, 1'b1);
        line(16, 1'b0);
        for (int i = 0; i < nb; i++) line(16, d[i]);
        if (pen) line(16, pb);
        line(16, stopv);
        line(16, 1'b1);
    endtask

    task automatic do_pop();
        pop = 1'b1;
        @(negedge clk);
        pop = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11 reset ready", int'(data_ready_o), 0);
        chk("R11 reset push", int'(push_o), 0);
        chk("R11 reset flags", int'({err_parity_o, err_frame_o, err_break_o, err_overrun_o, fifo_err_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: glitches of 3 and of exactly 8 ticks are rejected
        line(20, 1'b1);
        line(3, 1'b0);
        line(30, 1'b1);
        line(8, 1'b0);
        line(30, 1'b1);
        chk("R1 no char after glitch", int'(data_ready_o), 0);

        // R2/R7: 8N1 byte, then drained
        send_frame(8'hA5, 8, 0, 0, 0, 1);
        chk("R7 ready after frame", int'(data_ready_o), 1);
        chk("R2 8-bit data", int'(rd_data_o), 'hA5);
        do_pop();
        chk("R7 ready clears when empty", int'(data_ready_o), 0);
        do_pop();
        chk("R7 pop on empty ignored", int'(data_ready_o), 0);

        // R2: short word lengths
        send_frame(8'hF5, 5, 0, 0, 0, 1);
        chk("R2 5-bit data", int'(rd_data_o), 'h15);
        do_pop();
        send_frame(8'h2A, 6, 0, 0, 0, 1);
        chk("R2 6-bit data", int'(rd_data_o), 'h2A);
        do_pop();
        send_frame(8'h41, 7, 1, 1, 0, 1);
        chk("R4 good even parity", int'(err_parity_o), 0);
        chk("R2 7-bit data", int'(rd_data_o), 'h41);
        do_pop();

        // R4/R9/R10: bad parity entry followed by a good one
        send_frame(8'h3C, 8, 1, 0, 1, 1);
        chk("R4 bad odd parity", int'(err_parity_o), 1);
        chk("R10 fifo error set", int'(fifo_err_o), 1);
        send_frame(8'h3C, 8, 1, 0, 0, 1);
        do_pop();
        chk("R9 head flags of good entry", int'(err_parity_o), 0);
        chk("R10 fifo error clears", int'(fifo_err_o), 0);
        do_pop();

        // R5: framing error without break
        send_frame(8'h55, 8, 0, 0, 0, 0);
        chk("R5 framing flag", int'(err_frame_o), 1);
        chk("R6 no break on data", int'(err_break_o), 0);
        do_pop();

        // R6: break
        send_frame(8'h00, 8, 0, 0, 0, 0);
        chk("R6 break flag", int'(err_break_o), 1);
        chk("R6 break framing", int'(err_frame_o), 1);
        do_pop();

        // R8: fill then overflow
        for (int i = 0; i < DEPTH; i++) send_frame(8'(16 + i), 8, 0, 0, 0, 1);
        chk("R8 no overrun at full", int'(err_overrun_o), 0);
        send_frame(8'hEE, 8, 0, 0, 0, 1);
        chk("R8 overrun set", int'(err_overrun_o), 1);
        chk("R8 head kept", int'(rd_data_o), 16);
        do_pop();
        chk("R8 overrun cleared by pop", int'(err_overrun_o), 0);
        for (int i = 1; i < DEPTH; i++) begin
            chk("R8 discarded char absent", int'(rd_data_o), 16 + i);
            do_pop();
        end
        chk("R7 drained", int'(data_ready_o), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule